// File: doc/BRIEF.md
# Prediction Abort Input Stage

This block is the input-channel stage of an on-chip network router in a coherence scheme that issues speculative fetches ahead of demand. Request packets that arrive on the channel are held in a small queue before the router forwards them. A packet whose abort flag is set cancels a prediction. The stage then discards every queued speculative request whose line address lies in the cancelled range. It forwards the abort packet downstream and follows it with an invalidation packet bound for the directory.

The stage can also raise an abort of its own. A local prediction is tracked as a base address, a length and a timeout counter. If the predicted data has not arrived when the counter runs out, that is a temporal miss. If the data arrives but no remote access fell inside the predicted range in the meantime, that is a spatial miss. Either miss produces the same abort, invalidate and discard sequence as a received abort packet. It uses the local node number as the source.

Top module: `pab_input_stage`

## Requirements
- R1: While reset is held, and once it has been released, q_valid and dn_valid are 0 and in_ready is 1 until traffic arrives.
- R2: A packet with in_abort = 0 is a request. Accepted requests appear on the q port in arrival order, and each one holds steady while q_ready is low.
- R3: A packet with in_abort = 1 is an abort. It is accepted only while no abort is in progress, and otherwise in_ready is low for it. Once accepted, it is presented downstream first, with dn_abort = 1, dn_inval = 0, and its own address and source.
- R4: After the abort handshake, an invalidation packet follows with dn_abort = 0, dn_inval = 1 and the same address and source. After that handshake, dn_valid drops.
- R5: An abort stays active from the cycle after acceptance up to and including the cycle of its downstream handshake. During that time, any queued request with base <= addr < base + len is discarded and never shown on q. The remaining entries keep their order. For a received abort, len is cfg_range_len, and len = 0 discards nothing.
- R6: Requests that arrive while an abort is active are dropped if they fall in its range, and queued normally if they do not.
- R7: Once the abort packet has been handed downstream, discarding stops, even while the invalidation is still pending.
- R8: pred_issue arms a prediction with pred_base, pred_len and cfg_timeout. Suppose pred_done is not sampled within cfg_timeout cycles of the issue edge. Then dn_valid rises one cycle after expiry with an abort packet carrying pred_base and source NODE_ID.
- R9: pred_done ends the prediction. If no remote access inside [pred_base, pred_base + pred_len) was sampled since the issue, including the pred_done cycle itself, an abort follows one cycle later.
- R10: A remote access inside the range prevents the spatial abort. A remote access outside it does not prevent it. If pred_done arrives in time, no temporal abort follows.
- R11: A received abort takes precedence over an internally raised one. The internal abort waits, and it is presented only after the received abort's invalidation has completed.
- R12: in_ready is low for requests while the queue holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming packet valid |
| in_ready | output | 1 | Incoming packet accepted |
| in_abort | input | 1 | Abort flag of incoming packet (1 = abort) |
| in_addr | input | AW | Line address of incoming packet |
| in_src | input | SW | Source node of incoming packet |
| q_valid | output | 1 | Queued request available to the router |
| q_ready | input | 1 | Router takes the queued request |
| q_addr | output | AW | Address of queued request |
| q_src | output | SW | Source of queued request |
| pred_issue | input | 1 | Arm a local prediction |
| pred_base | input | AW | Predicted range base |
| pred_len | input | AW | Predicted range length |
| cfg_timeout | input | TW | Cycles allowed for predicted data |
| cfg_range_len | input | AW | Range length applied to received aborts |
| remote_valid | input | 1 | A remote access was observed |
| remote_addr | input | AW | Address of the remote access |
| pred_done | input | 1 | Predicted data has arrived |
| dn_valid | output | 1 | Downstream packet valid |
| dn_ready | input | 1 | Downstream accepts packet |
| dn_abort | output | 1 | Downstream packet is the abort |
| dn_inval | output | 1 | Downstream packet is the directory invalidation |
| dn_addr | output | AW | Downstream packet base address |
| dn_src | output | SW | Downstream packet source node |

## Verification
The delicate overlap is the cycle in which an abort becomes active while the router is popping the queue head. The bench holds q_ready high across the acceptance of an abort. The head taken on the acceptance edge is legitimate. The next head lies inside the range, so it must not show on q in the following cycle. The judgement is the exact sequence of addresses seen on q. A second overlap comes from letting a local timeout expire while a received abort is still waiting downstream. The order of the downstream packets shows which abort won.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_INV  = 2'd2
  } ab_state_e;

  // true when a lies in [base, base + len); len of zero covers nothing
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] len);
    return (a >= base) && ((a - base) < len);
  endfunction

endpackage

// File: rtl/pab_queue.sv
module pab_queue
  import pab_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SW    = 4,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_src,
  output logic          full,
  input  logic          kill,
  input  logic [AW-1:0] kill_base,
  input  logic [AW-1:0] kill_len,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [AW-1:0] q_addr,
  output logic [SW-1:0] q_src
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [SW-1:0]    src_q  [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] kmask;
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             head_live, occupied, push, pop, wr_drop;

  // parallel range compare on every stored entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign kmask[i] = kill && vld_q[i] &&
                      in_window(32'(addr_q[i]), 32'(kill_base), 32'(kill_len));
  end

  assign occupied  = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_live = vld_q[rd_ptr_q] && !kmask[rd_ptr_q];
  assign q_valid   = occupied && head_live;
  assign q_addr    = addr_q[rd_ptr_q];
  assign q_src     = src_q[rd_ptr_q];
  // a discarded head is retired silently without being offered
  assign pop       = occupied && (!head_live || q_ready);
  assign wr_drop   = kill && in_window(32'(wr_addr), 32'(kill_base), 32'(kill_len));
  assign push      = wr_en && !wr_drop;

  always_comb begin
    vld_d    = vld_q & ~kmask;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (pop) begin
      vld_d[rd_ptr_q] = 1'b0;
      rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push) begin
      vld_d[wr_ptr_q] = 1'b1;
      wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      vld_q    <= vld_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic we;
    assign we = push && (wr_ptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        src_q[i]  <= '0;
      end else if (we) begin
        addr_q[i] <= wr_addr;
        src_q[i]  <= wr_src;
      end
    end
  end

endmodule

// File: rtl/pab_trigger.sv
module pab_trigger
  import pab_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pred_issue,
  input  logic [AW-1:0] pred_base,
  input  logic [AW-1:0] pred_len,
  input  logic [TW-1:0] cfg_timeout,
  input  logic          remote_valid,
  input  logic [AW-1:0] remote_addr,
  input  logic          pred_done,
  input  logic          take,
  output logic          trig_valid,
  output logic [AW-1:0] trig_base,
  output logic [AW-1:0] trig_len
);

  logic          armed_q, armed_d;
  logic          seen_q, seen_d;
  logic          sp_q, sp_d;
  logic          tm_q, tm_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [AW-1:0] base_q, len_q;
  logic          hit;

  assign hit = remote_valid &&
               in_window(32'(remote_addr), 32'(base_q), 32'(len_q));

  always_comb begin
    armed_d = armed_q;
    seen_d  = seen_q;
    sp_d    = sp_q;
    tm_d    = tm_q;
    timer_d = timer_q;
    if (take) begin
      sp_d = 1'b0;
      tm_d = 1'b0;
    end
    if (pred_issue) begin
      armed_d = 1'b1;
      seen_d  = 1'b0;
      sp_d    = 1'b0;
      tm_d    = 1'b0;
      timer_d = cfg_timeout;
    end else if (armed_q) begin
      if (hit) seen_d = 1'b1;
      if (pred_done) begin
        // data arrived in time; spatial check closes the window
        armed_d = 1'b0;
        if (!seen_q && !hit) sp_d = 1'b1;
      end else if (timer_q <= TW'(1)) begin
        armed_d = 1'b0;
        tm_d    = 1'b1;
      end else begin
        timer_d = timer_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      sp_q    <= 1'b0;
      tm_q    <= 1'b0;
      timer_q <= '0;
    end else begin
      armed_q <= armed_d;
      seen_q  <= seen_d;
      sp_q    <= sp_d;
      tm_q    <= tm_d;
      timer_q <= timer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (pred_issue) begin
      base_q <= pred_base;
      len_q  <= pred_len;
    end
  end

  assign trig_valid = sp_q || tm_q;
  assign trig_base  = base_q;
  assign trig_len   = len_q;

endmodule

// File: rtl/pab_ctrl.sv
module pab_ctrl
  import pab_pkg::*;
#(
  parameter int              AW      = 16,
  parameter int              SW      = 4,
  parameter logic [SW-1:0]   NODE_ID = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_req,
  input  logic [AW-1:0] ext_addr,
  input  logic [SW-1:0] ext_src,
  input  logic [AW-1:0] ext_len,
  input  logic          trig_valid,
  input  logic [AW-1:0] trig_base,
  input  logic [AW-1:0] trig_len,
  input  logic          dn_ready,
  output logic          idle,
  output logic          take_trig,
  output logic          kill,
  output logic [AW-1:0] kill_base,
  output logic [AW-1:0] kill_len,
  output logic          dn_valid,
  output logic          dn_abort,
  output logic          dn_inval,
  output logic [AW-1:0] dn_addr,
  output logic [SW-1:0] dn_src
);

  ab_state_e     state_q, state_d;
  logic [AW-1:0] base_q, base_d, len_q, len_d;
  logic [SW-1:0] src_q, src_d;
  logic          ext_go, load;

  assign idle      = (state_q == ST_IDLE);
  assign ext_go    = ext_req && idle;
  assign take_trig = idle && trig_valid && !ext_req;
  assign load      = ext_go || take_trig;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load)     state_d = ST_FWD;
      ST_FWD:  if (dn_ready) state_d = ST_INV;
      ST_INV:  if (dn_ready) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
    base_d = ext_go ? ext_addr : trig_base;
    len_d  = ext_go ? ext_len  : trig_len;
    src_d  = ext_go ? ext_src  : NODE_ID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      src_q  <= '0;
    end else if (load) begin
      base_q <= base_d;
      len_q  <= len_d;
      src_q  <= src_d;
    end
  end

  assign kill      = (state_q == ST_FWD);
  assign kill_base = base_q;
  assign kill_len  = len_q;
  assign dn_valid  = !idle;
  assign dn_abort  = (state_q == ST_FWD);
  assign dn_inval  = (state_q == ST_INV);
  assign dn_addr   = base_q;
  assign dn_src    = src_q;

endmodule

// File: rtl/pab_input_stage.sv
module pab_input_stage
  import pab_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            SW      = 4,
  parameter int            DEPTH   = 4,
  parameter int            TW      = 8,
  parameter logic [SW-1:0] NODE_ID = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_abort,
  input  logic [AW-1:0] in_addr,
  input  logic [SW-1:0] in_src,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [AW-1:0] q_addr,
  output logic [SW-1:0] q_src,
  input  logic          pred_issue,
  input  logic [AW-1:0] pred_base,
  input  logic [AW-1:0] pred_len,
  input  logic [TW-1:0] cfg_timeout,
  input  logic [AW-1:0] cfg_range_len,
  input  logic          remote_valid,
  input  logic [AW-1:0] remote_addr,
  input  logic          pred_done,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_abort,
  output logic          dn_inval,
  output logic [AW-1:0] dn_addr,
  output logic [SW-1:0] dn_src
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          q_full, ctrl_idle, take_trig, kill;
  logic          trig_valid;
  logic [AW-1:0] trig_base, trig_len, kill_base, kill_len;
  logic          wr_en, ext_req;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ext_req  = in_valid && in_abort;
  assign wr_en    = in_valid && !in_abort && !q_full;
  assign in_ready = in_abort ? ctrl_idle : !q_full;

  pab_queue #(.AW(AW), .SW(SW), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (in_addr),
    .wr_src    (in_src),
    .full      (q_full),
    .kill      (kill),
    .kill_base (kill_base),
    .kill_len  (kill_len),
    .q_valid   (q_valid),
    .q_ready   (q_ready),
    .q_addr    (q_addr),
    .q_src     (q_src)
  );

  pab_trigger #(.AW(AW), .TW(TW)) u_trig (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pred_issue   (pred_issue),
    .pred_base    (pred_base),
    .pred_len     (pred_len),
    .cfg_timeout  (cfg_timeout),
    .remote_valid (remote_valid),
    .remote_addr  (remote_addr),
    .pred_done    (pred_done),
    .take         (take_trig),
    .trig_valid   (trig_valid),
    .trig_base    (trig_base),
    .trig_len     (trig_len)
  );

  pab_ctrl #(.AW(AW), .SW(SW), .NODE_ID(NODE_ID)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ext_req    (ext_req),
    .ext_addr   (in_addr),
    .ext_src    (in_src),
    .ext_len    (cfg_range_len),
    .trig_valid (trig_valid),
    .trig_base  (trig_base),
    .trig_len   (trig_len),
    .dn_ready   (dn_ready),
    .idle       (ctrl_idle),
    .take_trig  (take_trig),
    .kill       (kill),
    .kill_base  (kill_base),
    .kill_len   (kill_len),
    .dn_valid   (dn_valid),
    .dn_abort   (dn_abort),
    .dn_inval   (dn_inval),
    .dn_addr    (dn_addr),
    .dn_src     (dn_src)
  );

endmodule

// File: rtl/pab_input_stage_chk.sv
module pab_input_stage_chk
  import pab_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_abort,
  input logic          in_ready,
  input logic          q_valid,
  input logic          q_ready,
  input logic [AW-1:0] q_addr,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic          dn_abort,
  input logic          dn_inval,
  input logic [AW-1:0] dn_addr,
  input logic [AW-1:0] kill_len
);

  assert_abort_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_valid) |-> (dn_abort && !dn_inval));

  assert_dn_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) &&
                                 $stable(dn_abort) && $stable(dn_inval)));

  assert_busy_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && in_valid && in_abort) |-> !in_ready);

  assert_inval_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && dn_abort) |=> (dn_valid && dn_inval && !dn_abort &&
                                            $stable(dn_addr)));

  assert_kind_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> $onehot({dn_abort, dn_inval}));

  assert_kill_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_abort && q_valid) |->
      !in_window(32'(q_addr), 32'(dn_addr), 32'(kill_len)));

  assert_q_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> ((q_valid && $stable(q_addr)) || (dn_valid && dn_abort)));

endmodule

bind pab_input_stage pab_input_stage_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_abort (in_abort),
  .in_ready (in_ready),
  .q_valid  (q_valid),
  .q_ready  (q_ready),
  .q_addr   (q_addr),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready),
  .dn_abort (dn_abort),
  .dn_inval (dn_inval),
  .dn_addr  (dn_addr),
  .kill_len (kill_len)
);

// File: tb/pab_input_stage_bench.sv
module pab_input_stage_bench;

  localparam time        CLK_PERIOD = 10;
  localparam int         AW = 16;
  localparam int         SW = 4;
  localparam int         DEPTH = 4;
  localparam int         TW = 8;
  localparam logic [3:0] NODE = 4'hA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_abort = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [SW-1:0] in_src = '0;
  logic          in_ready;
  logic          q_valid, q_ready = 1'b0;
  logic [AW-1:0] q_addr;
  logic [SW-1:0] q_src;
  logic          pred_issue = 1'b0, remote_valid = 1'b0, pred_done = 1'b0;
  logic [AW-1:0] pred_base = '0, pred_len = '0, remote_addr = '0, cfg_range_len = '0;
  logic [TW-1:0] cfg_timeout = '0;
  logic          dn_valid, dn_ready = 1'b0, dn_abort, dn_inval;
  logic [AW-1:0] dn_addr;
  logic [SW-1:0] dn_src;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [AW-1:0] got [16];
  logic [AW-1:0] expv [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pab_input_stage #(.AW(AW), .SW(SW), .DEPTH(DEPTH), .TW(TW), .NODE_ID(NODE)) u_pab_input_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_abort(in_abort),
    .in_addr(in_addr), .in_src(in_src),
    .q_valid(q_valid), .q_ready(q_ready), .q_addr(q_addr), .q_src(q_src),
    .pred_issue(pred_issue), .pred_base(pred_base), .pred_len(pred_len),
    .cfg_timeout(cfg_timeout), .cfg_range_len(cfg_range_len),
    .remote_valid(remote_valid), .remote_addr(remote_addr), .pred_done(pred_done),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_abort(dn_abort),
    .dn_inval(dn_inval), .dn_addr(dn_addr), .dn_src(dn_src)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic ab);
    in_valid = 1'b1; in_abort = ab; in_addr = a; in_src = s;
    @(negedge clk);
    in_valid = 1'b0; in_abort = 1'b0;
  endtask

  task automatic drain_q(output int n);
    n = 0;
    q_ready = 1'b1;
    for (int k = 0; k < 12; k++) begin
      if (q_valid) begin got[n] = q_addr; n++; end
      @(negedge clk);
    end
    q_ready = 1'b0;
  endtask

  task automatic cmp_q(input string req, input int n, input int ne);
    chk(req, 32'(n), 32'(ne));
    for (int i = 0; i < ne && i < n; i++) chk(req, 32'(got[i]), 32'(expv[i]));
  endtask

  task automatic finish_dn();
    dn_ready = 1'b1;
    repeat (2) @(negedge clk);
    dn_ready = 1'b0;
  endtask

  initial begin
    int n;
    int ne;
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1 q_valid", 32'(q_valid), 0);
    chk("R1 dn_valid", 32'(dn_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 q_valid after release", 32'(q_valid), 0);
    chk("R1 dn_valid after release", 32'(dn_valid), 0);

    // R5 R3 R4: sweep abort base and range length against a full queue
    for (int b = 14; b <= 24; b++) begin
      for (int li = 0; li < 4; li++) begin
        int len;
        len = (li == 3) ? 4 : li;
        cfg_range_len = AW'(len);
        for (int i = 0; i < 4; i++) push(AW'(16 + 2 * i), SW'(i), 1'b0);
        push(AW'(b), 4'h5, 1'b1);
        ne = 0;
        for (int i = 0; i < 4; i++) begin
          int a;
          a = 16 + 2 * i;
          if (!(a >= b && (a - b) < len)) begin expv[ne] = AW'(a); ne++; end
        end
        drain_q(n);
        cmp_q("R5 survivors", n, ne);
        chk("R3 abort valid", 32'(dn_valid), 1);
        chk("R3 abort flag", 32'(dn_abort), 1);
        chk("R3 abort addr", 32'(dn_addr), 32'(b));
        chk("R3 abort src", 32'(dn_src), 32'h5);
        dn_ready = 1'b1;
        @(negedge clk);
        chk("R4 inval flag", 32'({dn_valid, dn_inval, dn_abort}), 32'b110);
        chk("R4 inval addr", 32'(dn_addr), 32'(b));
        chk("R4 inval src", 32'(dn_src), 32'h5);
        @(negedge clk);
        dn_ready = 1'b0;
        chk("R4 dn idle", 32'(dn_valid), 0);
      end
    end

    // R5 R2: abort activation coincides with a head pop
    cfg_range_len = 16'd2;
    for (int i = 0; i < 4; i++) push(AW'(16 + 2 * i), SW'(i), 1'b0);
    chk("R2 head before abort", 32'({q_valid, q_addr}), 32'({1'b1, 16'h10}));
    q_ready = 1'b1;
    push(16'h12, 4'h6, 1'b1);
    chk("R5 killed head hidden", 32'(q_valid), 0);
    drain_q(n);
    expv[0] = 16'h14; expv[1] = 16'h16;
    cmp_q("R5 collision order", n, 2);
    finish_dn();

    // R6 R7: arrivals during and after the discard window
    cfg_range_len = 16'd4;
    push(16'h30, 4'h1, 1'b1);
    push(16'h31, 4'h2, 1'b0);
    push(16'h50, 4'h3, 1'b0);
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R7 in invalidation phase", 32'(dn_inval), 1);
    push(16'h32, 4'h4, 1'b0);
    finish_dn();
    drain_q(n);
    expv[0] = 16'h50; expv[1] = 16'h32;
    cmp_q("R6 R7 arrivals", n, 2);

    // R12 R2 R3: full queue and busy abort channel
    for (int i = 0; i < 4; i++) push(AW'(96 + i), SW'(i), 1'b0);
    in_valid = 1'b1; in_abort = 1'b0; #1;
    chk("R12 full rejects request", 32'(in_ready), 0);
    in_abort = 1'b1; #1;
    chk("R12 abort open when idle", 32'(in_ready), 1);
    in_valid = 1'b0; in_abort = 1'b0;
    @(negedge clk);
    drain_q(n);
    for (int i = 0; i < 4; i++) expv[i] = AW'(96 + i);
    cmp_q("R2 order", n, 4);
    cfg_range_len = 16'd0;
    push(16'h70, 4'h2, 1'b1);
    in_valid = 1'b1; in_abort = 1'b1; in_addr = 16'h77; #1;
    chk("R3 busy rejects abort", 32'(in_ready), 0);
    in_valid = 1'b0; in_abort = 1'b0;
    @(negedge clk);
    chk("R3 first abort kept", 32'(dn_addr), 32'h70);
    finish_dn();

    // R8 R10: timeout sweep, data arrival at every offset
    pred_base = 16'h80; pred_len = 16'd8;
    for (int t = 1; t <= 6; t++) begin
      for (int d = 1; d <= t + 1; d++) begin
        cfg_timeout = TW'(t);
        pred_issue = 1'b1;
        @(negedge clk);
        pred_issue = 1'b0;
        for (int k = 1; k <= t + 1; k++) begin
          if (k == 1) begin remote_valid = 1'b1; remote_addr = 16'h81; end
          if (k == d) pred_done = 1'b1;
          if (k == t + 1) chk("R8 no early abort", 32'(dn_valid), 0);
          @(negedge clk);
          remote_valid = 1'b0; pred_done = 1'b0;
        end
        if (d > t) begin
          chk("R8 timeout abort", 32'({dn_valid, dn_abort}), 32'b11);
          chk("R8 timeout base", 32'(dn_addr), 32'h80);
          chk("R8 timeout src", 32'(dn_src), 32'(NODE));
          finish_dn();
        end else begin
          repeat (2) @(negedge clk);
          chk("R10 in-time arrival", 32'(dn_valid), 0);
        end
      end
    end

    // R9 R10: remote access positions around the range edges
    pred_base = 16'h40; pred_len = 16'd4; cfg_timeout = 8'd20;
    for (int ri = 0; ri < 5; ri++) begin
      logic [AW-1:0] ra;
      logic          spatial;
      ra = (ri == 0) ? 16'h3F : (ri == 1) ? 16'h40 : (ri == 2) ? 16'h43 : 16'h44;
      spatial = (ri == 0) || (ri >= 3);
      pred_issue = 1'b1;
      @(negedge clk);
      pred_issue = 1'b0;
      for (int k = 1; k <= 4; k++) begin
        if (k == 1 && ri < 4) begin remote_valid = 1'b1; remote_addr = ra; end
        if (k == 3) pred_done = 1'b1;
        if (k == 4) chk("R9 no early abort", 32'(dn_valid), 0);
        @(negedge clk);
        remote_valid = 1'b0; pred_done = 1'b0;
      end
      chk(spatial ? "R9 spatial abort" : "R10 hit suppresses abort", 32'(dn_valid), 32'(spatial));
      if (spatial) begin
        chk("R9 spatial base", 32'(dn_addr), 32'h40);
        finish_dn();
      end
    end

    // R11: received abort outranks a local timeout
    pred_base = 16'h90; pred_len = 16'd4; cfg_timeout = 8'd2; cfg_range_len = 16'd1;
    pred_issue = 1'b1;
    @(negedge clk);
    pred_issue = 1'b0;
    push(16'h20, 4'h7, 1'b1);
    repeat (3) @(negedge clk);
    chk("R11 received abort first", 32'(dn_addr), 32'h20);
    chk("R11 received src", 32'(dn_src), 32'h7);
    dn_ready = 1'b1;
    @(negedge clk);
    chk("R11 received inval", 32'({dn_inval, dn_addr}), 32'({1'b1, 16'h20}));
    @(negedge clk);
    chk("R11 gap", 32'(dn_valid), 0);
    @(negedge clk);
    chk("R11 local abort", 32'({dn_abort, dn_addr}), 32'({1'b1, 16'h90}));
    chk("R11 local src", 32'(dn_src), 32'(NODE));
    @(negedge clk);
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R11 done", 32'(dn_valid), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule